// File: doc/BRIEF.md
# Serial Gain Programmer for a Two-Channel Amplifier

This block sets the gain of a two-channel programmable-gain amplifier through an SPI bus that other devices also use. The host presents one 4-bit gain code per channel and pulses a start strobe. If both codes are legal, the block requests the bus. Once the bus is granted, it pulls the amplifier's active-low select down and shifts one 8-bit setting word out with a generated serial clock. It then raises the select again, and that rising edge is the moment the amplifier applies the new gain.

During the shift, the amplifier returns the setting it held before. The block captures that word and presents it when the transfer ends, together with a flag that says whether the stored setting is known. The block also drives the amplifier's active-high shutdown line, which doubles as the amplifier's reset. While shutdown is requested, all transfers are blocked.

Top module: `pga_spi_ctrl`

## Requirements
- R1: The word sent is {code_b, code_a}: channel B in bits 7..4, channel A in bits 3..0. It is sent most significant bit first, in exactly 8 bits per transfer.
- R2: amp_cs_n stays low from before the first rising sclk edge until after the last falling sclk edge. It rises only at the end of a full 8-bit shift or on a shutdown abort.
- R3: Gain codes map to these inverting gains: 0000 to 0, 0001 to -1, 0010 to -2, 0011 to -5, 0100 to -10, 0101 to -20, 0110 to -50, 0111 to -100. Codes 1000 to 1111 would exceed the magnitude limit of 100, so they are illegal.
- R4: sclk idles low and each half period lasts HALF_DIV clock cycles. mosi changes only on falling sclk edges. miso is sampled on rising sclk edges.
- R5: When a transfer finishes, echo holds the 8 bits shifted in on miso, first bit in bit 7.
- R6: An accepted start raises bus_req the next cycle. amp_cs_n stays high until bus_grant is seen. bus_req falls one cycle after amp_cs_n rises, and is high whenever amp_cs_n is low.
- R7: amp_shdn follows shdn_req one cycle later and is high during reset. While shdn_req or amp_shdn is high, start is ignored and any transfer in progress is abandoned (amp_cs_n high, sclk low, bus_req low).
- R8: A start with any illegal code, while idle and not shut down, gives a one-cycle pulse on bad_code in the next cycle, and no bus request is made.
- R9: busy is high from the cycle after an accepted start until the transfer ends. A start while busy is ignored. done pulses for exactly one cycle, one cycle after amp_cs_n rises.
- R10: echo_valid is cleared by reset and by shutdown, and is set only when a transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to program the gains |
| code_a | input | 4 | Gain code for channel A |
| code_b | input | 4 | Gain code for channel B |
| shdn_req | input | 1 | Host request to shut the amplifier down |
| bus_grant | input | 1 | Shared bus granted to this block |
| miso | input | 1 | Serial echo from the amplifier |
| bus_req | output | 1 | Shared bus request |
| amp_cs_n | output | 1 | Active-low amplifier select |
| sclk | output | 1 | Generated serial clock |
| mosi | output | 1 | Serial setting data |
| amp_shdn | output | 1 | Active-high amplifier shutdown and reset |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| echo | output | 8 | Previous setting returned by the amplifier |
| echo_valid | output | 1 | echo holds a setting read since the last shutdown |
| bad_code | output | 1 | One-cycle pulse on an illegal code |

## Verification
A bit counter that is off by one shows up in the first transfer: the amplifier model counts 9 or 7 sclk rising edges, so it stores nothing, and echo is wrong in the very next done cycle. A sampling-phase or shift-direction fault corrupts the word stored in the model, or the echo, within that same transfer. A fault in the legality check shows up within one cycle of start, as a missing or extra bad_code pulse or bus request. A stuck state during shutdown shows up two cycles after shdn_req, as a select, clock or request that stays active.

// File: rtl/pga_spi_pkg.sv
package pga_spi_pkg;

  localparam int unsigned CODE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_FIN
  } xfer_state_t;

  // Gain magnitude of each code (all gains are inverting). Unlisted codes give a large value.
  function automatic int unsigned gain_mag(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return 0;
      4'd1:    return 1;
      4'd2:    return 2;
      4'd3:    return 5;
      4'd4:    return 10;
      4'd5:    return 20;
      4'd6:    return 50;
      4'd7:    return 100;
      default: return 1000;
    endcase
  endfunction

  function automatic logic code_ok(input logic [CODE_W-1:0] code,
                                   input int unsigned max_gain);
    return gain_mag(code) <= max_gain;
  endfunction

  function automatic logic [2*CODE_W-1:0] pack_word(input logic [CODE_W-1:0] cb,
                                                    input logic [CODE_W-1:0] ca);
    return {cb, ca};
  endfunction

endpackage

// File: rtl/pga_sck_gen.sv
module pga_sck_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);

  // R4: a half period is never shorter than HALF_DIV cycles
  generate
    if (HALF_DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    end
  endgenerate

endmodule

// File: rtl/pga_shifter.sv
module pga_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_out,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi_bit,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load) begin
        tx_q <= load_word;
      end else if (shift_out) begin
        tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
      if (sample) begin
        rx_q <= {rx_q[WORD_W-2:0], miso};
      end
    end
  end

  assign mosi_bit = tx_q[WORD_W-1];
  assign rx_word  = rx_q;

  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(shift_out || sample)); // R1

endmodule

// File: rtl/pga_spi_ctrl.sv
module pga_spi_ctrl
  import pga_spi_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned MAX_GAIN = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CODE_W-1:0]   code_a,
  input  logic [CODE_W-1:0]   code_b,
  input  logic                shdn_req,
  input  logic                bus_grant,
  input  logic                miso,
  output logic                bus_req,
  output logic                amp_cs_n,
  output logic                sclk,
  output logic                mosi,
  output logic                amp_shdn,
  output logic                busy,
  output logic                done,
  output logic [2*CODE_W-1:0] echo,
  output logic                echo_valid,
  output logic                bad_code
);
  localparam int unsigned WORD_W = 2 * CODE_W;
  localparam int unsigned BC_W   = $clog2(WORD_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

  xfer_state_t       state_q;
  logic [BC_W-1:0]   bit_cnt_q;
  logic              cs_n_q, sck_q, req_q, shdn_q, done_q, bad_q, evalid_q;
  logic [WORD_W-1:0] echo_q;

  // named internal events
  logic shdn_any, idle, codes_ok, start_ok, start_bad;
  logic run, tick, rise_evt, fall_evt, last_fall;
  logic mosi_bit;
  logic [WORD_W-1:0] rx_word;

  assign shdn_any  = shdn_req || shdn_q;
  assign idle      = (state_q == ST_IDLE);
  assign codes_ok  = code_ok(code_a, MAX_GAIN) && code_ok(code_b, MAX_GAIN);
  assign start_ok  = start && idle && !shdn_any && codes_ok;
  assign start_bad = start && idle && !shdn_any && !codes_ok;
  assign run       = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);
  assign rise_evt  = tick && ((state_q == ST_LEAD) || ((state_q == ST_SHIFT) && !sck_q));
  assign fall_evt  = tick && (state_q == ST_SHIFT) && sck_q;
  assign last_fall = fall_evt && (bit_cnt_q == LAST_BIT);

  pga_sck_gen #(.HALF_DIV(HALF_DIV)) i_sck_gen (
    .clk  (clk),
    .rst_n(rst_n && !shdn_any),
    .run  (run),
    .tick (tick)
  );

  pga_shifter #(.WORD_W(WORD_W)) i_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_word(pack_word(code_b, code_a)),
    .shift_out(fall_evt && !last_fall),
    .sample   (rise_evt),
    .miso     (miso),
    .mosi_bit (mosi_bit),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      cs_n_q    <= 1'b1;
      sck_q     <= 1'b0;
      req_q     <= 1'b0;
      shdn_q    <= 1'b1;
      done_q    <= 1'b0;
      bad_q     <= 1'b0;
      evalid_q  <= 1'b0;
      echo_q    <= '0;
    end else begin
      shdn_q <= shdn_req;
      done_q <= 1'b0;
      bad_q  <= start_bad;
      if (shdn_any) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        cs_n_q    <= 1'b1;
        sck_q     <= 1'b0;
        req_q     <= 1'b0;
        evalid_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (start_ok) begin
              state_q <= ST_REQ;
              req_q   <= 1'b1;
            end
          end
          ST_REQ: begin
            if (bus_grant) begin
              state_q <= ST_LEAD;
              cs_n_q  <= 1'b0;
            end
          end
          ST_LEAD: begin
            if (tick) begin
              sck_q   <= 1'b1;
              state_q <= ST_SHIFT;
            end
          end
          ST_SHIFT: begin
            if (fall_evt) begin
              sck_q <= 1'b0;
              if (last_fall) begin
                bit_cnt_q <= '0;
                state_q   <= ST_TRAIL;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end else if (rise_evt) begin
              sck_q <= 1'b1;
            end
          end
          ST_TRAIL: begin
            if (tick) begin
              cs_n_q  <= 1'b1;
              state_q <= ST_FIN;
            end
          end
          ST_FIN: begin
            done_q   <= 1'b1;
            req_q    <= 1'b0;
            echo_q   <= rx_word;
            evalid_q <= 1'b1;
            state_q  <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign bus_req    = req_q;
  assign amp_cs_n   = cs_n_q;
  assign sclk       = sck_q;
  assign mosi       = mosi_bit;
  assign amp_shdn   = shdn_q;
  assign busy       = !idle;
  assign done       = done_q;
  assign echo       = echo_q;
  assign echo_valid = evalid_q;
  assign bad_code   = bad_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    amp_cs_n |-> !sclk); // R4
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R4
  AST_CS_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_cs_n) |-> (($past(state_q) == ST_TRAIL) || $past(shdn_any))); // R2
  AST_REQ_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_cs_n |-> bus_req); // R6
  AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    amp_shdn |-> (amp_cs_n && !bus_req && !busy)); // R7
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (amp_cs_n && !$past(amp_cs_n, 2))); // R9
  AST_BAD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |-> (!bus_req && amp_cs_n)); // R8
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(echo_valid) |-> done); // R10

endmodule

// File: tb/test_pga_spi_ctrl.sv
module test_pga_spi_ctrl;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] code_a = '0, code_b = '0;
  logic shdn_req = 1'b0;
  logic bus_grant = 1'b0;
  logic grant_en = 1'b1;
  logic miso;
  logic bus_req, amp_cs_n, sclk, mosi, amp_shdn, busy, done, echo_valid, bad_code;
  logic [7:0] echo;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pga_spi_ctrl #(.HALF_DIV(HALF), .MAX_GAIN(100)) i_pga_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .code_a(code_a), .code_b(code_b),
    .shdn_req(shdn_req), .bus_grant(bus_grant), .miso(miso),
    .bus_req(bus_req), .amp_cs_n(amp_cs_n), .sclk(sclk), .mosi(mosi),
    .amp_shdn(amp_shdn), .busy(busy), .done(done), .echo(echo),
    .echo_valid(echo_valid), .bad_code(bad_code)
  );

  always @(posedge clk) bus_grant <= bus_req && grant_en;

  // amplifier model
  logic [7:0] sl_store = 8'h3C;
  logic [7:0] sl_snap = '0, sl_rx = '0;
  int sl_bits = 0, sl_xfers = 0;

  always @(negedge amp_cs_n or posedge sclk) begin
    if (!sclk) begin
      sl_snap = sl_store;
      sl_bits = 0;
    end else if (!amp_cs_n) begin
      sl_rx = {sl_rx[6:0], mosi};
      sl_bits++;
    end
  end
  assign miso = (sl_bits < 8) ? sl_snap[7 - sl_bits] : 1'b0;

  always @(posedge amp_cs_n or posedge amp_shdn) begin
    if (amp_shdn) sl_store = 8'h00;
    else if (sl_bits == 8) begin
      sl_store = sl_rx;
      sl_xfers++;
    end
  end

  // sclk high-width monitor
  int hi_cnt = 0, hi_last = 0;
  always @(posedge clk) begin
    if (sclk) hi_cnt++;
    else begin
      if (hi_cnt != 0) hi_last = hi_cnt;
      hi_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // magnitude from the 1-2-5 series: code c>=1 gives {1,2,5}[(c-1)%3] * 10^((c-1)/3)
  function automatic int bench_mag(input int c);
    int m;
    if (c == 0) return 0;
    m = ((c - 1) % 3 == 0) ? 1 : (((c - 1) % 3 == 1) ? 2 : 5);
    for (int k = 0; k < (c - 1) / 3; k++) m = m * 10;
    return m;
  endfunction

  task automatic wait_done;
    while (!done) @(negedge clk);
  endtask

  task automatic xfer(input int a, input int b);
    logic [7:0] exp_prev;
    int x0;
    bit legal;
    legal = (bench_mag(a) <= 100) && (bench_mag(b) <= 100);
    exp_prev = sl_store;
    x0 = sl_xfers;
    code_a = 4'(a); code_b = 4'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!legal) begin
      chk(bad_code == 1'b1, "R3/R8 bad_code pulse", bad_code, 1);
      chk(busy == 1'b0, "R8 no busy on bad code", busy, 0);
      @(negedge clk);
      chk(bad_code == 1'b0, "R8 bad_code one cycle", bad_code, 0);
      chk(bus_req == 1'b0, "R8 no bus request", bus_req, 0);
      chk(sl_xfers == x0, "R8 no transfer", sl_xfers, x0);
    end else begin
      chk(busy == 1'b1 && bad_code == 1'b0, "R3/R9 accepted, busy", busy, 1);
      chk(bus_req == 1'b1, "R6 bus_req after start", bus_req, 1);
      wait_done();
      chk(amp_cs_n == 1'b1, "R9 done after cs high", amp_cs_n, 1);
      chk(bus_req == 1'b0, "R6 bus released", bus_req, 0);
      chk(sl_xfers == x0 + 1, "R2 one full 8-bit frame", sl_xfers, x0 + 1);
      chk(sl_store == 8'((b << 4) | a), "R1 word order", sl_store, (b << 4) | a);
      chk(echo == exp_prev, "R5 echo of previous setting", echo, exp_prev);
      chk(echo_valid == 1'b1, "R10 echo_valid set", echo_valid, 1);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R9 done single pulse", done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(amp_cs_n == 1'b1 && sclk == 1'b0, "R4 reset idle lines", {amp_cs_n, sclk}, 2);
    chk(bus_req == 1'b0 && busy == 1'b0 && done == 1'b0, "R6 reset quiet", bus_req, 0);
    chk(echo_valid == 1'b0, "R10 reset echo_valid", echo_valid, 0);
    chk(amp_shdn == 1'b1, "R7 shutdown in reset", amp_shdn, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(amp_shdn == 1'b0, "R7 shutdown follows request", amp_shdn, 0);
    @(negedge clk);

    // full sweep of both codes
    for (int b = 0; b < 16; b++)
      for (int a = 0; a < 16; a++)
        xfer(a, b);
    chk(hi_last == HALF, "R4 sclk half period", hi_last, HALF);

    // start while busy is ignored
    begin
      int x0;
      x0 = sl_xfers;
      code_a = 4'd1; code_b = 4'd2; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (amp_cs_n) @(negedge clk);
      code_a = 4'd3; code_b = 4'd4; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done();
      repeat (60) @(negedge clk);
      chk(sl_xfers == x0 + 1, "R9 start while busy ignored", sl_xfers, x0 + 1);
      chk(sl_store == 8'h21, "R9 first setting kept", sl_store, 8'h21);
      chk(bus_req == 1'b0, "R9 no second request", bus_req, 0);
    end

    // grant delayed
    grant_en = 1'b0;
    code_a = 4'd7; code_b = 4'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(bus_req == 1'b1 && amp_cs_n == 1'b1, "R6 waits for grant", amp_cs_n, 1);
    chk(sclk == 1'b0, "R6 no clock before grant", sclk, 0);
    grant_en = 1'b1;
    wait_done();
    chk(sl_store == 8'h67, "R6 transfer after grant", sl_store, 8'h67);
    @(negedge clk);

    // shutdown blocks starts and clears echo_valid
    shdn_req = 1'b1;
    @(negedge clk);
    chk(amp_shdn == 1'b1, "R7 shutdown output", amp_shdn, 1);
    chk(echo_valid == 1'b0, "R10 shutdown clears valid", echo_valid, 0);
    code_a = 4'd2; code_b = 4'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(bus_req == 1'b0 && amp_cs_n == 1'b1 && busy == 1'b0, "R7 start ignored in shutdown", bus_req, 0);
    shdn_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(amp_shdn == 1'b0 && echo_valid == 1'b0, "R10 unknown after release", echo_valid, 0);
    xfer(5, 6);

    // abort mid-transfer
    code_a = 4'd1; code_b = 4'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!sclk) @(negedge clk);
    shdn_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(amp_cs_n == 1'b1 && sclk == 1'b0 && bus_req == 1'b0, "R7 abort releases bus",
        {amp_cs_n, sclk, bus_req}, 4);
    chk(sl_store == 8'h00, "R7 aborted word not applied", sl_store, 0);
    shdn_req = 1'b0;
    repeat (2) @(negedge clk);
    xfer(4, 3);
    report();
  end

endmodule